// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for an 8-bit processor core and picks one to serve at each instruction boundary. There are twelve sources: an undefined-opcode trap, a non-maskable input, three external level lines, and seven internal peripheral requests. The peripheral requests are two timers, two DMA channels, a clocked serial port and two asynchronous serial channels. Each source has its own pending latch. When the core signals an instruction boundary, the block grants the highest-priority pending source. The other pending sources stay latched for later boundaries.

For each grant the block produces a 16-bit address and a flag. The flag tells whether the address is a fixed restart address that the core jumps to directly, or a table location that the core reads to fetch the handler address. The block also holds the two interrupt-enable flip-flops of the core (main and save copy) and clears them on acceptance. It signals a wake-up from halt, and it holds the small vector-base register that places the internal vector table. The core itself, the stack push and the table read are outside the block.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Source indices in fixed priority order, 0 being highest: 0 trap, 1 NMI, 2 ext line 0, 3 ext line 1, 4 ext line 2, 5 timer 0, 6 timer 1, 7 DMA 0, 8 DMA 1, 9 clocked serial, 10 async serial 0, 11 async serial 1. When `boundary` is high and any latch is pending, the next cycle carries `grant`=1 and `grant_idx` = the lowest pending index. There is at most one grant per boundary, and `grant` is never high unless `boundary` was high in the cycle before.
- R2: A pending latch stays set until its own source is granted; the granted latch clears on the grant edge. If a new request for the granted source arrives in the same cycle, the clear wins.
- R3: External line n becomes pending in a cycle only when (`ext_irq[n]` or its hold latch) is 1, `ext_en[n]` is 1, `iff1` is 1 and `ei_shadow` is 0.
- R4: A peripheral request pulse `per_req[j]` (j=0..6 maps to index 5+j) is latched only when `iff1` is 1 and `ei_shadow` is 0. `trap_req` is latched unconditionally.
- R5: NMI is latched on a 0-to-1 change of `nmi_in` between consecutive cycles (the previous value is 0 after reset). Its grant gives address 0x0066 with `grant_tbl`=0.
- R6: For indices 3 to 11, `grant_addr` = {`i_reg`, `vb_rd` + 2*(index-3)} with `grant_tbl`=1. The inputs used are those present in the boundary cycle.
- R7: Index 2 depends on `int_mode`. Value 1 gives 0x0038 with `grant_tbl`=0. Value 2 gives {`i_reg`, `dev_vec`} with `grant_tbl`=1. Values 0 and 3 give {8'h00, `dev_vec` & 8'h38} with `grant_tbl`=0. A trap grant gives 0x0000 with `grant_tbl`=0.
- R8: An NMI grant clears `iff1` and leaves `iff2`. Any other grant clears both. Without a grant, `di_cmd` clears both, else `ei_cmd` sets both, else `retn_cmd` copies `iff2` into `iff1`.
- R9: `ext_hold_set[n]` sets a hold latch that acts as an asserted line n. The latch is released only by the grant of line n.
- R10: `vb_wd[7:5]` is stored when `vb_we` is 1. `vb_rd` returns the stored bits at 7:5 with bits 4:0 always 0.
- R11: `halt_exit` is 1 together with a grant when `cpu_halted` was 1 in the boundary cycle, and 0 otherwise.
- R12: After reset no latch is pending, `grant`, `iff1`, `iff2` and `vb_rd` are 0.
- R13: In a cycle without a grant, `grant_idx`, `grant_addr`, `grant_tbl` and `halt_exit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq | input | 3 | External level request lines |
| ext_en | input | 3 | Per-line enable bits |
| ext_hold_set | input | 3 | Pulse: assert line in hold mode |
| nmi_in | input | 1 | Non-maskable input, edge detected |
| trap_req | input | 1 | Undefined-opcode trap pulse |
| per_req | input | 7 | Internal peripheral request pulses |
| ei_shadow | input | 1 | Core is in the shadow after enable-interrupts |
| boundary | input | 1 | Instruction boundary strobe |
| cpu_halted | input | 1 | Core is halted |
| ei_cmd | input | 1 | Enable-interrupts command |
| di_cmd | input | 1 | Disable-interrupts command |
| retn_cmd | input | 1 | Return-from-NMI: restore main enable from save copy |
| int_mode | input | 2 | Interrupt mode for ext line 0 |
| i_reg | input | 8 | Vector page register of the core |
| dev_vec | input | 8 | Vector byte supplied by the device on line 0 |
| vb_we | input | 1 | Vector-base write enable |
| vb_wd | input | 8 | Vector-base write data |
| vb_rd | output | 8 | Vector-base read value |
| grant | output | 1 | Grant strobe |
| grant_idx | output | 4 | Granted source index |
| grant_addr | output | 16 | Restart or table address |
| grant_tbl | output | 1 | 1 when grant_addr is a table location |
| halt_exit | output | 1 | Grant wakes the core from halt |
| iff1 | output | 1 | Main interrupt enable |
| iff2 | output | 1 | Saved interrupt enable |

## Verification
Bursts of simultaneous peripheral and line requests followed by a run of boundaries check that the grants come out in strict priority order and one per boundary. Single requests made with the enable bit clear, with `iff1` low, or during the shadow check that the gating term drops each request. Hold pulses on a low line and NMI edges while interrupts are disabled show that hold release and edge detection work apart from the level path. Long runs of random mixed traffic with random modes, vector bases and enable commands are compared against a cycle model built from the requirements, which catches errors in vector arithmetic, mode selection and flip-flop updates.

// File: rtl/vec_irq_ctrl_pkg.sv
// Shared constants and types for the vectored interrupt controller.
// Assumes the fixed source layout: trap, NMI, external lines, then
// internal peripherals, in falling priority.
package vec_irq_ctrl_pkg;

    localparam int SRC_TRAP = 0;
    localparam int SRC_NMI  = 1;
    localparam int SRC_EXT0 = 2;
    localparam int SRC_TBL0 = 3;  // first source served through the vector table

    localparam logic [15:0] ADDR_TRAP  = 16'h0000;
    localparam logic [15:0] ADDR_NMI   = 16'h0066;
    localparam logic [15:0] ADDR_RST38 = 16'h0038;
    localparam logic [7:0]  RST_MASK   = 8'h38;

    typedef enum logic [1:0] {
        IM_DEVICE_RST = 2'd0,
        IM_FIXED      = 2'd1,
        IM_TABLE      = 2'd2,
        IM_RESERVED   = 2'd3
    } irq_mode_e;

endpackage

// File: rtl/irq_pend_bank.sv
// Bank of per-source pending latches.
// A set request latches the bit. A clear addressed by index takes priority
// over a set of the same bit in the same cycle.
module irq_pend_bank #(
    parameter int SRC_N = 12,
    localparam int IDX_W = $clog2(SRC_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] set_vec,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [SRC_N-1:0] pend
);

    for (genvar b = 0; b < SRC_N; b++) begin : g_bit
        // Hold one source's request until it is served.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[b] <= 1'b0;
            else if (clr_en && (clr_idx == IDX_W'(b)))
                pend[b] <= 1'b0;
            else if (set_vec[b])
                pend[b] <= 1'b1;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: the lowest set index wins.
// Purely combinational; the output index is 0 when nothing is pending.
module irq_prio_pick #(
    parameter int SRC_N = 12,
    localparam int IDX_W = $clog2(SRC_N)
) (
    input  logic [SRC_N-1:0] pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from lowest priority upward so the highest-priority bit is written last.
    always_comb begin
        any = |pend;
        idx = '0;
        for (int k = SRC_N - 1; k >= 0; k--) begin
            if (pend[k])
                idx = IDX_W'(k);
        end
    end

endmodule

// File: rtl/irq_vec_gen.sv
// Vector-base register and grant address formation.
// Only the top VB_HI bits of the base are stored. The table sources use
// base + 2*offset; the offset is below 2^(8-VB_HI-1), so no carry reaches the stored bits.
module irq_vec_gen #(
    parameter int IDX_W = 4,
    parameter int VB_HI = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vb_we,
    input  logic [VB_HI-1:0] vb_wbits,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       int_mode,
    input  logic [7:0]       i_reg,
    input  logic [7:0]       dev_vec,
    output logic [7:0]       vb_rd,
    output logic [15:0]      vaddr,
    output logic             vtbl
);
    import vec_irq_ctrl_pkg::*;

    localparam int VB_LO = 8 - VB_HI;

    logic [VB_HI-1:0] vb_q;
    logic [IDX_W-1:0] off;
    logic [7:0]       low;

    // Store the writable upper bits of the vector base.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vb_q <= '0;
        else if (vb_we)
            vb_q <= vb_wbits;
    end

    assign vb_rd = {vb_q, {VB_LO{1'b0}}};
    assign off   = idx - IDX_W'(SRC_TBL0);
    assign low   = vb_rd + 8'({off, 1'b0});

    // Pick the restart or table address for the selected source.
    always_comb begin
        vaddr = {i_reg, low};
        vtbl  = 1'b1;
        if (idx == IDX_W'(SRC_TRAP)) begin
            vaddr = ADDR_TRAP;
            vtbl  = 1'b0;
        end else if (idx == IDX_W'(SRC_NMI)) begin
            vaddr = ADDR_NMI;
            vtbl  = 1'b0;
        end else if (idx == IDX_W'(SRC_EXT0)) begin
            case (irq_mode_e'(int_mode))
                IM_FIXED: begin
                    vaddr = ADDR_RST38;
                    vtbl  = 1'b0;
                end
                IM_TABLE: begin
                    vaddr = {i_reg, dev_vec};
                    vtbl  = 1'b1;
                end
                default: begin
                    vaddr = {8'h00, dev_vec & RST_MASK};
                    vtbl  = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_enable_ff.sv
// Main and saved interrupt-enable flip-flops.
// An accepted interrupt overrides any enable or disable command in the same cycle.
module irq_enable_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic take_nmi,
    input  logic ei_cmd,
    input  logic di_cmd,
    input  logic retn_cmd,
    output logic iff1,
    output logic iff2
);

    // Update both enables from acceptance and core commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (take) begin
            iff1 <= 1'b0;
            if (!take_nmi)
                iff2 <= 1'b0;
        end else if (di_cmd) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (ei_cmd) begin
            iff1 <= 1'b1;
            iff2 <= 1'b1;
        end else if (retn_cmd) begin
            iff1 <= iff2;
        end
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
// Prioritized vectored interrupt controller, top level.
// Gates and latches the requests, edge-detects NMI and keeps the hold latches.
// At a boundary it registers one grant with its address; the grant appears
// one cycle after the boundary.
// Assumes boundary pulses come from the core, and that the core does the stack push
// and the table read.
module vec_irq_ctrl #(
    parameter int EXT_N = 3,
    parameter int PER_N = 7,
    parameter int VB_HI = 3,
    localparam int SRC_N = 2 + EXT_N + PER_N,
    localparam int IDX_W = $clog2(SRC_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXT_N-1:0] ext_irq,
    input  logic [EXT_N-1:0] ext_en,
    input  logic [EXT_N-1:0] ext_hold_set,
    input  logic             nmi_in,
    input  logic             trap_req,
    input  logic [PER_N-1:0] per_req,
    input  logic             ei_shadow,
    input  logic             boundary,
    input  logic             cpu_halted,
    input  logic             ei_cmd,
    input  logic             di_cmd,
    input  logic             retn_cmd,
    input  logic [1:0]       int_mode,
    input  logic [7:0]       i_reg,
    input  logic [7:0]       dev_vec,
    input  logic             vb_we,
    input  logic [7:0]       vb_wd,
    output logic [7:0]       vb_rd,
    output logic             grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic [15:0]      grant_addr,
    output logic             grant_tbl,
    output logic             halt_exit,
    output logic             iff1,
    output logic             iff2
);
    import vec_irq_ctrl_pkg::*;

    localparam int PER_BASE = SRC_EXT0 + EXT_N;

    logic [SRC_N-1:0] set_vec;
    logic [SRC_N-1:0] pend;
    logic [EXT_N-1:0] hold_q;
    logic [EXT_N-1:0] line_eff;
    logic             nmi_prev;
    logic             gate_ok;
    logic             any;
    logic [IDX_W-1:0] pick;
    logic             take;
    logic [15:0]      vaddr;
    logic             vtbl;
    logic             vb_unused;

    assign vb_unused = ^vb_wd[7-VB_HI:0];
    assign gate_ok   = iff1 & ~ei_shadow;
    assign line_eff  = ext_irq | hold_q;
    assign take      = boundary & any;

    // Build the per-source set requests.
    always_comb begin
        set_vec           = '0;
        set_vec[SRC_TRAP] = trap_req;
        set_vec[SRC_NMI]  = nmi_in & ~nmi_prev;
        for (int n = 0; n < EXT_N; n++)
            set_vec[SRC_EXT0 + n] = line_eff[n] & ext_en[n] & gate_ok;
        for (int j = 0; j < PER_N; j++)
            set_vec[PER_BASE + j] = per_req[j] & gate_ok;
    end

    // Remember the previous NMI level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_prev <= 1'b0;
        else
            nmi_prev <= nmi_in;
    end

    for (genvar n = 0; n < EXT_N; n++) begin : g_hold
        // Keep a hold-mode assertion until its own line is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_q[n] <= 1'b0;
            else if (take && (pick == IDX_W'(SRC_EXT0 + n)))
                hold_q[n] <= 1'b0;
            else if (ext_hold_set[n])
                hold_q[n] <= 1'b1;
        end
    end

    irq_pend_bank #(.SRC_N(SRC_N)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_en  (take),
        .clr_idx (pick),
        .pend    (pend)
    );

    irq_prio_pick #(.SRC_N(SRC_N)) u_pick (
        .pend (pend),
        .any  (any),
        .idx  (pick)
    );

    irq_vec_gen #(.IDX_W(IDX_W), .VB_HI(VB_HI)) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .vb_we    (vb_we),
        .vb_wbits (vb_wd[7 -: VB_HI]),
        .idx      (pick),
        .int_mode (int_mode),
        .i_reg    (i_reg),
        .dev_vec  (dev_vec),
        .vb_rd    (vb_rd),
        .vaddr    (vaddr),
        .vtbl     (vtbl)
    );

    irq_enable_ff u_iff (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_nmi (pick == IDX_W'(SRC_NMI)),
        .ei_cmd   (ei_cmd),
        .di_cmd   (di_cmd),
        .retn_cmd (retn_cmd),
        .iff1     (iff1),
        .iff2     (iff2)
    );

    // Register the grant; all grant fields are zero in idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !take) begin
            grant      <= 1'b0;
            grant_idx  <= '0;
            grant_addr <= '0;
            grant_tbl  <= 1'b0;
            halt_exit  <= 1'b0;
        end else begin
            grant      <= 1'b1;
            grant_idx  <= pick;
            grant_addr <= vaddr;
            grant_tbl  <= vtbl;
            halt_exit  <= cpu_halted;
        end
    end

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
// Temporal checks on the controller's ports, attached by bind.
module vec_irq_ctrl_chk #(
    parameter int IDX_W = 4,
    parameter int SRC_N = 12,
    parameter int VB_HI = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             boundary,
    input logic             grant,
    input logic [IDX_W-1:0] grant_idx,
    input logic [15:0]      grant_addr,
    input logic             grant_tbl,
    input logic             halt_exit,
    input logic             iff1,
    input logic             iff2,
    input logic [7:0]       vb_rd
);

    // R1
    grant_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(boundary));

    // R1
    grant_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (grant_idx < IDX_W'(SRC_N)));

    // R5
    nmi_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && grant_idx == IDX_W'(1)) |-> (grant_addr == 16'h0066 && !grant_tbl));

    // R6
    table_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && grant_idx >= IDX_W'(3)) |-> grant_tbl);

    // R8
    nmi_keeps_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && grant_idx == IDX_W'(1)) |-> (!iff1 && iff2 == $past(iff2)));

    // R8
    accept_clears_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && grant_idx != IDX_W'(1)) |-> (!iff1 && !iff2));

    // R10
    vb_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vb_rd[7-VB_HI:0] == '0);

    // R11
    halt_exit_with_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_exit |-> grant);

    // R13
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> (grant_idx == '0 && grant_addr == 16'h0000 && !grant_tbl));

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.IDX_W(IDX_W), .SRC_N(SRC_N), .VB_HI(VB_HI)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .grant      (grant),
    .grant_idx  (grant_idx),
    .grant_addr (grant_addr),
    .grant_tbl  (grant_tbl),
    .halt_exit  (halt_exit),
    .iff1       (iff1),
    .iff2       (iff2),
    .vb_rd      (vb_rd)
);

// File: tb/sim_vec_irq_ctrl.sv
// Self-checking bench: a cycle model built from the requirements runs beside
// the design. Directed cases come first, then seeded random traffic.
module sim_vec_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  ext_irq, ext_en, ext_hold_set;
    logic        nmi_in, trap_req;
    logic [6:0]  per_req;
    logic        ei_shadow, boundary, cpu_halted, ei_cmd, di_cmd, retn_cmd;
    logic [1:0]  int_mode;
    logic [7:0]  i_reg, dev_vec;
    logic        vb_we;
    logic [7:0]  vb_wd;
    logic [7:0]  vb_rd;
    logic        grant;
    logic [3:0]  grant_idx;
    logic [15:0] grant_addr;
    logic        grant_tbl, halt_exit, iff1, iff2;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    // model state
    logic [11:0] m_pend;
    logic [2:0]  m_hold;
    logic        m_nmi_prev, m_iff1, m_iff2;
    logic [7:0]  m_vb;
    logic        m_grant, m_tbl, m_hexit;
    logic [3:0]  m_idx;
    logic [15:0] m_addr;

    always #2 clk = ~clk;

    vec_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .ext_en(ext_en),
        .ext_hold_set(ext_hold_set), .nmi_in(nmi_in), .trap_req(trap_req),
        .per_req(per_req), .ei_shadow(ei_shadow), .boundary(boundary),
        .cpu_halted(cpu_halted), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
        .retn_cmd(retn_cmd), .int_mode(int_mode), .i_reg(i_reg),
        .dev_vec(dev_vec), .vb_we(vb_we), .vb_wd(vb_wd), .vb_rd(vb_rd),
        .grant(grant), .grant_idx(grant_idx), .grant_addr(grant_addr),
        .grant_tbl(grant_tbl), .halt_exit(halt_exit), .iff1(iff1), .iff2(iff2)
    );

    // Expected {table flag, address} for a source, from R5, R6 and R7.
    function automatic logic [16:0] exp_vec(int idx, logic [1:0] md,
                                            logic [7:0] ir, logic [7:0] dv,
                                            logic [7:0] vbf);
        if (idx == 0) return {1'b0, 16'h0000};
        if (idx == 1) return {1'b0, 16'h0066};
        if (idx == 2) begin
            if (md == 2'd1) return {1'b0, 16'h0038};
            if (md == 2'd2) return {1'b1, ir, dv};
            return {1'b0, 8'h00, dv & 8'h38};
        end
        return {1'b1, ir, vbf + 8'((idx - 3) * 2)};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic quiet_inputs();
        ext_hold_set = '0; trap_req = 0; per_req = '0; boundary = 0;
        ei_cmd = 0; di_cmd = 0; retn_cmd = 0; vb_we = 0; ei_shadow = 0;
    endtask

    // Advance the model by one clock using the inputs now on the pins.
    task automatic model_step();
        logic [11:0] setv;
        logic        take;
        int          pk;
        logic [16:0] v;
        if (!rst_n) begin
            m_pend = '0; m_hold = '0; m_nmi_prev = 0; m_iff1 = 0; m_iff2 = 0;
            m_vb = '0; m_grant = 0; m_idx = '0; m_addr = '0; m_tbl = 0; m_hexit = 0;
            return;
        end
        setv = '0;
        setv[0] = trap_req;
        setv[1] = nmi_in & ~m_nmi_prev;
        for (int n = 0; n < 3; n++)
            setv[2+n] = (ext_irq[n] | m_hold[n]) & ext_en[n] & m_iff1 & ~ei_shadow;
        for (int j = 0; j < 7; j++)
            setv[5+j] = per_req[j] & m_iff1 & ~ei_shadow;
        take = boundary && (m_pend != '0);
        pk = 0;
        for (int k = 11; k >= 0; k--) if (m_pend[k]) pk = k;
        v = exp_vec(pk, int_mode, i_reg, dev_vec, m_vb);
        m_grant = take;
        m_idx   = take ? 4'(pk) : 4'd0;
        m_addr  = take ? v[15:0] : 16'h0;
        m_tbl   = take ? v[16] : 1'b0;
        m_hexit = take ? cpu_halted : 1'b0;
        m_pend = m_pend | setv;
        for (int n = 0; n < 3; n++) if (ext_hold_set[n]) m_hold[n] = 1'b1;
        if (take) begin
            m_pend[pk] = 1'b0;
            if (pk >= 2 && pk <= 4) m_hold[pk-2] = 1'b0;
            m_iff1 = 0;
            if (pk != 1) m_iff2 = 0;
        end else if (di_cmd) begin
            m_iff1 = 0; m_iff2 = 0;
        end else if (ei_cmd) begin
            m_iff1 = 1; m_iff2 = 1;
        end else if (retn_cmd) begin
            m_iff1 = m_iff2;
        end
        if (vb_we) m_vb = {vb_wd[7:5], 5'b0};
        m_nmi_prev = nmi_in;
    endtask

    // One clock: update the model, let the edge pass, compare at the falling edge.
    task automatic cycle();
        string atag;
        model_step();
        @(posedge clk);
        @(negedge clk);
        if (!m_grant) atag = "R13";
        else if (m_idx == 1) atag = "R5";
        else if (m_idx <= 2) atag = "R7";
        else atag = "R6";
        check(cur_tag, "grant", 32'(grant), 32'(m_grant));
        check(cur_tag, "grant_idx", 32'(grant_idx), 32'(m_idx));
        check(atag, "grant_addr", 32'(grant_addr), 32'(m_addr));
        check(atag, "grant_tbl", 32'(grant_tbl), 32'(m_tbl));
        check("R8", "iff", 32'({iff1, iff2}), 32'({m_iff1, m_iff2}));
        check("R11", "halt_exit", 32'(halt_exit), 32'(m_hexit));
        check("R10", "vb_rd", 32'(vb_rd), 32'(m_vb));
        quiet_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        rst_n = 0; ext_irq = '0; ext_en = '0; nmi_in = 0; cpu_halted = 0;
        int_mode = 2'd1; i_reg = 8'h40; dev_vec = 8'hA5; vb_wd = '0;
        quiet_inputs();
        @(negedge clk);
        cur_tag = "R12";
        repeat (3) cycle();
        rst_n = 1;
        cycle();
        // R12: explicit reset-state check
        check("R12", "reset grant/iff/vb", 32'({grant, iff1, iff2, vb_rd}), 32'h0);

        // R10: write all ones, only the top three bits survive
        cur_tag = "R10";
        vb_we = 1; vb_wd = 8'hFF; cycle();
        check("R10", "vb_rd after FF", 32'(vb_rd), 32'hE0);
        vb_we = 1; vb_wd = 8'h5F; cycle();

        // R4: peripheral pulse while disabled is dropped
        cur_tag = "R4";
        per_req = 7'h7F; cycle();
        boundary = 1; cycle();
        cycle();
        check("R4", "no grant while disabled", 32'(grant), 32'h0);
        // trap while disabled is latched
        trap_req = 1; cycle();
        boundary = 1; cycle();
        check("R4", "trap grant idx", 32'({grant, grant_idx}), 32'h10);

        // R1: burst of requests served in priority order
        cur_tag = "R1";
        ei_cmd = 1; cycle();
        per_req = 7'b1010101; ext_en = 3'b111; ext_irq = 3'b010; cycle();
        ext_irq = 3'b000; cycle();
        for (int b = 0; b < 8; b++) begin
            boundary = 1; cycle();
            cycle();
        end

        // R3: enable bit clear and shadow both block a line
        cur_tag = "R3";
        ei_cmd = 1; cycle();
        ext_en = 3'b000; ext_irq = 3'b111; cycle();
        ext_irq = 3'b000; boundary = 1; cycle();
        cycle();
        check("R3", "disabled line grant", 32'(grant), 32'h0);
        ext_en = 3'b111; ext_irq = 3'b100; ei_shadow = 1; cycle();
        ext_irq = 3'b000; boundary = 1; cycle();
        cycle();
        check("R3", "shadowed line grant", 32'(grant), 32'h0);

        // R9: hold on a low line, released by its grant
        cur_tag = "R9";
        ext_hold_set = 3'b001; int_mode = 2'd2; cycle();
        cycle();
        boundary = 1; cycle();
        check("R9", "hold grant", 32'({grant, grant_idx}), 32'h12);
        ei_cmd = 1; cycle();
        cycle();
        boundary = 1; cycle();
        check("R9", "hold released", 32'(grant), 32'h0);

        // R5 and R8: NMI edge while enabled keeps iff2
        cur_tag = "R5";
        nmi_in = 1; cycle();
        cycle();
        boundary = 1; cpu_halted = 1; cycle();
        check("R8", "nmi iff", 32'({iff1, iff2}), 32'b01);
        check("R11", "halt exit", 32'(halt_exit), 32'h1);
        retn_cmd = 1; cpu_halted = 0; cycle();
        check("R8", "retn restore", 32'(iff1), 32'h1);
        nmi_in = 0; cycle();

        // R7: line 0 in each mode
        cur_tag = "R7";
        for (int md = 0; md < 4; md++) begin
            int_mode = 2'(md); dev_vec = 8'hFF;
            ei_cmd = 1; cycle();
            ext_irq = 3'b001; cycle();
            ext_irq = 3'b000; boundary = 1; cycle();
            cycle();
        end

        // R2: clear wins over same-cycle request of the granted source
        cur_tag = "R2";
        ei_cmd = 1; cycle();
        per_req = 7'b0000001; cycle();
        per_req = 7'b0000001; boundary = 1; cycle();
        boundary = 1; cycle();
        check("R2", "no second grant", 32'(grant), 32'h0);

        // random mixed traffic
        cur_tag = "R1";
        for (int c = 0; c < 20000; c++) begin
            if ($urandom % 16 == 0) ext_irq = 3'($urandom);
            if ($urandom % 32 == 0) ext_en = 3'($urandom);
            ext_hold_set = ($urandom % 40 == 0) ? 3'($urandom) : 3'b0;
            if ($urandom % 12 == 0) nmi_in = ~nmi_in;
            trap_req = ($urandom % 60 == 0);
            per_req = ($urandom % 4 == 0) ? 7'($urandom) : 7'b0;
            ei_shadow = ($urandom % 6 == 0);
            boundary = ($urandom % 3 == 0);
            cpu_halted = $urandom % 2;
            ei_cmd = ($urandom % 6 == 0);
            di_cmd = ($urandom % 30 == 0);
            retn_cmd = ($urandom % 20 == 0);
            int_mode = 2'($urandom);
            i_reg = 8'($urandom);
            dev_vec = 8'($urandom);
            vb_we = ($urandom % 50 == 0);
            vb_wd = 8'($urandom);
            cycle();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule